// File: doc/BRIEF.md
# Configurable Up/Down Timer Counter

This block is a 16-bit timer counter that advances once for every cycle in which its count-enable strobe is high while it is running. A two-bit direction field selects counting up, counting down, or counting up and then down. A separate bit selects whether the counter keeps going after each period (repeat) or stops after the first one (one-shot). A programmable maximum value, called the limit below, bounds the count to the range from zero to the limit, and so sets the length of the period. Each completed period produces a period event pulse one clock cycle long.

Control is by level. While `run_i` is high the timer runs. A preset input loads the starting value. The limit can be rewritten while the timer runs: a write is held pending and takes effect at the next point where the counter stands on the old limit. At that point the counter either carries on towards a larger limit or falls back to zero if the new limit is below the count.

The controller has four states. ST_IDLE: stopped. ST_UP: running, counting up. ST_DOWN: running, counting down. ST_HALT: a one-shot period has ended. The transitions are:
- ST_IDLE to ST_UP (up or up/down mode) or to ST_DOWN (down mode) when run rises.
- ST_UP and ST_DOWN swap with each other at the turnarounds in up/down mode. A preset returns the state to the direction the mode starts in.
- ST_UP or ST_DOWN to ST_HALT on the period event in one-shot mode.
- Any state to ST_IDLE when run falls.

Top module: `updown_timer`

## Requirements
- R1: After reset, `count_o` is 0, `busy_o`, `event_o` and `max_busy_o` are 0, and the limit register holds all ones.
- R2: Direction code 2'b00 (up; code 2'b11 also counts up): each enabled step adds one. A step taken at or above the limit gives 0, and `event_o` is 1 in the cycle that shows the 0. The period is limit+1 steps.
- R3: Direction code 2'b01 (down): each enabled step subtracts one. A step taken at 0 loads the limit, with `event_o` high in the cycle that shows the limit. The period is limit+1 steps.
- R4: Direction code 2'b10 (up/down), limit at least 1: the count climbs to the limit, then descends. A step taken at the limit gives limit-1. A step taken at 0 while descending gives 1 and raises `event_o`. `up_o` is 1 while ascending and 0 while descending. The period is 2*limit steps.
- R5: A preset sets the count to 0 in up and up/down modes and to the limit in down mode. Preset wins over an enabled step in the same cycle.
- R6: The count changes only in a cycle where the timer is running, `run_i` and `cnt_en_i` are both high, or a preset is applied. Otherwise the count holds.
- R7: In one-shot mode (`oneshot_i`=1), `busy_o` is 0 in the cycle the first event appears. Later strobes leave the count unchanged until `run_i` falls and rises again.
- R8: `busy_o` is 1 from the cycle after `run_i` rises until a stop. A stop is `run_i` falling or the end of a one-shot period.
- R9: A limit write is accepted only while `max_busy_o` is 0, and it raises `max_busy_o`. When the timer is idle the value takes effect on the next edge. When it is running, the value takes effect in the first cycle in which the count equals the old limit, and that cycle's step already uses it. `max_busy_o` then falls. Writes made while `max_busy_o` is 1 are dropped.
- R10: In repeat up counting, if a limit above the current count takes effect, counting continues up to the new limit. If the new limit is below the count, the next step gives 0 with an event.
- R11: `event_o` rises only in the cycle after an enabled step, and lasts one cycle per completed period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run level; low stops the timer |
| preset_i | input | 1 | Load the starting value for the mode |
| cnt_en_i | input | 1 | Count-enable strobe from the count clock |
| mode_i | input | 2 | Direction: 00 up, 01 down, 10 up/down, 11 up |
| oneshot_i | input | 1 | 1 one-shot, 0 repeat |
| max_we_i | input | 1 | Limit write strobe |
| max_wdata_i | input | CNT_W | Limit write value |
| count_o | output | CNT_W | Current count |
| busy_o | output | 1 | Timer running |
| up_o | output | 1 | 1 counting up, 0 counting down |
| max_busy_o | output | 1 | A limit write is pending |
| event_o | output | 1 | One-cycle period event |

## Verification
The checker examines every cycle for the following. The count holds unless a step or a preset occurs. Up steps below the limit add one. A down step at zero reloads the limit together with an event. A preset in up and up/down modes gives zero. A pending limit stays frozen until the count reaches it. Events follow only enabled steps. A one-shot event coincides with the timer going idle. Only the bench's scenarios show the following: the complete period sequences for each mode and limit, and the position of the turnarounds in up/down mode. They also show a pending limit taking effect at the old limit, the grow and shrink outcomes, the dropping of a second write, and the restart after a one-shot.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;

    typedef enum logic [1:0] {
        DIR_UP     = 2'b00,
        DIR_DOWN   = 2'b01,
        DIR_UPDOWN = 2'b10
    } dir_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UP,
        ST_DOWN,
        ST_HALT
    } tmr_state_e;

endpackage

// File: rtl/updown_timer_maxreg.sv
module updown_timer_maxreg #(
    parameter int unsigned      CNT_W     = 16,
    parameter logic [CNT_W-1:0] RESET_MAX = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             running_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] max_o,
    output logic [CNT_W-1:0] max_eff_o,
    output logic             busy_o
);
    logic             pend_q;
    logic [CNT_W-1:0] pend_val_q;
    logic [CNT_W-1:0] max_q;
    logic             apply_now;

    // A pending value lands when idle, or when the count sits on the old limit.
    assign apply_now = pend_q && (!running_i || (count_i == max_q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q     <= 1'b0;
            pend_val_q <= '0;
            max_q      <= RESET_MAX;
        end else if (apply_now) begin
            max_q  <= pend_val_q;
            pend_q <= 1'b0;
        end else if (we_i && !pend_q) begin
            pend_q     <= 1'b1;
            pend_val_q <= wdata_i;
        end
    end

    assign max_o     = max_q;
    assign max_eff_o = apply_now ? pend_val_q : max_q;
    assign busy_o    = pend_q;

endmodule

// File: rtl/updown_timer_core.sv
module updown_timer_core
    import updown_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             preset_i,
    input  logic             going_up_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] max_i,
    output logic [CNT_W-1:0] count_o,
    output logic             event_o,
    output logic             evt_o,
    output logic             flip_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nxt;
    logic             event_q;
    logic             is_bounce;

    assign is_bounce = (mode_i == DIR_UPDOWN);

    always_comb begin
        count_nxt = count_q;
        evt_o     = 1'b0;
        flip_o    = 1'b0;
        if (going_up_i) begin
            if (is_bounce) begin
                if (count_q > max_i) begin
                    count_nxt = '0;
                end else if (count_q == max_i) begin
                    if (max_i == '0) begin
                        count_nxt = '0;
                        evt_o     = 1'b1;
                    end else begin
                        count_nxt = max_i - ONE;
                        flip_o    = 1'b1;
                    end
                end else begin
                    count_nxt = count_q + ONE;
                end
            end else if (count_q >= max_i) begin
                count_nxt = '0;
                evt_o     = 1'b1;
            end else begin
                count_nxt = count_q + ONE;
            end
        end else begin
            if (count_q == '0) begin
                evt_o = 1'b1;
                if (is_bounce) begin
                    if (max_i == '0) begin
                        count_nxt = '0;
                    end else begin
                        count_nxt = ONE;
                        flip_o    = 1'b1;
                    end
                end else begin
                    count_nxt = max_i;
                end
            end else begin
                count_nxt = count_q - ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
            event_q <= 1'b0;
        end else if (preset_i) begin
            count_q <= (mode_i == DIR_DOWN) ? max_i : '0;
            event_q <= 1'b0;
        end else if (step_i) begin
            count_q <= count_nxt;
            event_q <= evt_o;
        end else begin
            event_q <= 1'b0;
        end
    end

    assign count_o = count_q;
    assign event_o = event_q;

endmodule

// File: rtl/updown_timer_fsm.sv
module updown_timer_fsm
    import updown_timer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic       preset_i,
    input  logic       step_i,
    input  logic       evt_i,
    input  logic       flip_i,
    input  logic       oneshot_i,
    input  logic [1:0] mode_i,
    output logic       busy_o,
    output logic       up_o,
    output logic       going_up_o
);
    tmr_state_e state_q;
    tmr_state_e state_d;
    tmr_state_e start_st;

    assign start_st = (mode_i == DIR_DOWN) ? ST_DOWN : ST_UP;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) state_d = start_st;
            end
            ST_UP, ST_DOWN: begin
                if (!run_i) begin
                    state_d = ST_IDLE;
                end else if (step_i && evt_i && oneshot_i) begin
                    state_d = ST_HALT;
                end else if (preset_i) begin
                    state_d = start_st;
                end else if (step_i && flip_i) begin
                    state_d = (state_q == ST_UP) ? ST_DOWN : ST_UP;
                end
            end
            ST_HALT: begin
                if (!run_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o     = 1'b0;
        up_o       = (mode_i != DIR_DOWN);
        going_up_o = 1'b1;
        unique case (state_q)
            ST_UP: begin
                busy_o = 1'b1;
                up_o   = 1'b1;
            end
            ST_DOWN: begin
                busy_o     = 1'b1;
                up_o       = 1'b0;
                going_up_o = 1'b0;
            end
            ST_IDLE, ST_HALT: begin
                busy_o = 1'b0;
            end
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/updown_timer.sv
module updown_timer #(
    parameter int unsigned      CNT_W     = 16,
    parameter logic [CNT_W-1:0] RESET_MAX = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             preset_i,
    input  logic             cnt_en_i,
    input  logic [1:0]       mode_i,
    input  logic             oneshot_i,
    input  logic             max_we_i,
    input  logic [CNT_W-1:0] max_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             busy_o,
    output logic             up_o,
    output logic             max_busy_o,
    output logic             event_o
);
    logic             step;
    logic             evt;
    logic             flip;
    logic             going_up;
    logic [CNT_W-1:0] max_cur;
    logic [CNT_W-1:0] max_eff;

    assign step = busy_o && run_i && cnt_en_i && !preset_i;

    updown_timer_maxreg #(
        .CNT_W    (CNT_W),
        .RESET_MAX(RESET_MAX)
    ) u_maxreg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (max_we_i),
        .wdata_i  (max_wdata_i),
        .running_i(busy_o),
        .count_i  (count_o),
        .max_o    (max_cur),
        .max_eff_o(max_eff),
        .busy_o   (max_busy_o)
    );

    updown_timer_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step),
        .preset_i  (preset_i),
        .going_up_i(going_up),
        .mode_i    (mode_i),
        .max_i     (max_eff),
        .count_o   (count_o),
        .event_o   (event_o),
        .evt_o     (evt),
        .flip_o    (flip)
    );

    updown_timer_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .preset_i  (preset_i),
        .step_i    (step),
        .evt_i     (evt),
        .flip_i    (flip),
        .oneshot_i (oneshot_i),
        .mode_i    (mode_i),
        .busy_o    (busy_o),
        .up_o      (up_o),
        .going_up_o(going_up)
    );

endmodule

// File: rtl/updown_timer_chk.sv
module updown_timer_chk
    import updown_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_i,
    input logic             preset_i,
    input logic             cnt_en_i,
    input logic [1:0]       mode_i,
    input logic             oneshot_i,
    input logic [CNT_W-1:0] count_o,
    input logic             busy_o,
    input logic             up_o,
    input logic             max_busy_o,
    input logic             event_o,
    input logic [CNT_W-1:0] max_cur,
    input logic [CNT_W-1:0] max_eff
);
    // R6: no step and no preset keeps the count
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(busy_o && run_i && cnt_en_i) && !preset_i) |=> $stable(count_o));

    // R2: an up step below the limit adds one
    p_up_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && up_o && run_i && cnt_en_i && !preset_i &&
         (mode_i == DIR_UP) && (count_o < max_cur))
        |=> (count_o == $past(count_o) + CNT_W'(1)));

    // R3: a down step at zero reloads the limit with an event
    p_down_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && run_i && cnt_en_i && !preset_i &&
         (mode_i == DIR_DOWN) && (count_o == '0))
        |=> ((count_o == $past(max_eff)) && event_o));

    // R5: preset in up or up/down mode gives zero
    p_preset_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preset_i && (mode_i != DIR_DOWN)) |=> (count_o == '0));

    // R9: a pending limit stays frozen while the count is elsewhere
    p_pend_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (max_busy_o && busy_o && (count_o != max_cur)) |=> $stable(max_cur));

    // R11: events only follow enabled steps
    p_event_on_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |-> $past(busy_o && run_i && cnt_en_i && !preset_i));

    // R7: a one-shot event comes with the timer stopped
    p_oneshot_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_o && $past(oneshot_i)) |-> !busy_o);

endmodule

bind updown_timer updown_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .preset_i  (preset_i),
    .cnt_en_i  (cnt_en_i),
    .mode_i    (mode_i),
    .oneshot_i (oneshot_i),
    .count_o   (count_o),
    .busy_o    (busy_o),
    .up_o      (up_o),
    .max_busy_o(max_busy_o),
    .event_o   (event_o),
    .max_cur   (max_cur),
    .max_eff   (max_eff)
);

// File: tb/updown_timer_tb.sv
module updown_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic         preset = 1'b0;
    logic         en = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         oneshot = 1'b0;
    logic         we = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] count;
    logic         busy, up, max_busy, evt;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_timer #(.CNT_W(W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .preset_i(preset),
        .cnt_en_i(en), .mode_i(mode), .oneshot_i(oneshot),
        .max_we_i(we), .max_wdata_i(wdata), .count_o(count),
        .busy_o(busy), .up_o(up), .max_busy_o(max_busy), .event_o(evt)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] m, input int lim, input logic os);
        run = 1'b0; preset = 1'b0; en = 1'b0; we = 1'b0;
        cyc();
        we = 1'b1; wdata = W'(lim);
        cyc();
        we = 1'b0;
        check("R9 busy after idle write", int'(max_busy), 1);
        cyc();
        check("R9 idle write applied", int'(max_busy), 0);
        mode = m; oneshot = os; preset = 1'b1;
        cyc();
        preset = 1'b0;
        check("R5 preset value", int'(count), (m == 2'b01) ? lim : 0);
        run = 1'b1;
        cyc();
        check("R8 busy after run", int'(busy), 1);
    endtask

    task automatic step_n(input int n);
        for (int i = 0; i < n; i++) begin
            en = 1'b1;
            cyc();
        end
        en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] mtab [3];
        mtab[0] = 2'b00; mtab[1] = 2'b01; mtab[2] = 2'b10;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        check("R1 count", int'(count), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 event", int'(evt), 0);
        check("R1 max_busy", int'(max_busy), 0);

        // Sweep of every mode over small limits
        for (int mi = 0; mi < 3; mi++) begin
            for (int lim = (mi == 2) ? 1 : 0; lim <= 6; lim++) begin
                int per;
                per = (mi == 2) ? 2 * lim : lim + 1;
                setup(mtab[mi], lim, 1'b0);
                for (int k = 1; k <= 3 * per + 1; k++) begin
                    int ec, ee, eu, p;
                    en = 1'b1;
                    cyc();
                    en = 1'b0;
                    if (mi == 0) begin
                        ec = k % (lim + 1); ee = (ec == 0); eu = 1;
                        check("R2 up count", int'(count), ec);
                        check("R2 up event", int'(evt), ee);
                    end else if (mi == 1) begin
                        ec = lim - (k % (lim + 1)); ee = ((k % (lim + 1)) == 0); eu = 0;
                        check("R3 down count", int'(count), ec);
                        check("R3 down event", int'(evt), ee);
                    end else begin
                        p  = k % (2 * lim);
                        ec = (p <= lim) ? p : 2 * lim - p;
                        ee = (p == 1 && k > 1);
                        eu = (p >= 1 && p <= lim);
                        check("R4 updown count", int'(count), ec);
                        check("R4 updown event", int'(evt), ee);
                    end
                    check("R4 direction flag", int'(up), eu);
                    if (k % 4 == 0) begin
                        cyc();
                        check("R6 hold without strobe", int'(count), ec);
                        check("R11 event one cycle", int'(evt), 0);
                    end
                end
                begin
                    int held;
                    held = int'(count);
                    run = 1'b0;
                    cyc();
                    check("R8 idle after run low", int'(busy), 0);
                    en = 1'b1;
                    cyc();
                    en = 1'b0;
                    check("R6 hold when stopped", int'(count), held);
                end
            end
        end

        // One-shot
        setup(2'b00, 3, 1'b1);
        step_n(4);
        check("R7 oneshot event", int'(evt), 1);
        check("R7 oneshot stopped", int'(busy), 0);
        check("R7 oneshot count", int'(count), 0);
        step_n(2);
        check("R7 halted count", int'(count), 0);
        check("R7 halted busy", int'(busy), 0);
        run = 1'b0; cyc();
        run = 1'b1; cyc();
        check("R7 restart busy", int'(busy), 1);
        step_n(1);
        check("R7 restart count", int'(count), 1);

        // Preset priority
        setup(2'b00, 7, 1'b0);
        step_n(3);
        preset = 1'b1; en = 1'b1;
        cyc();
        preset = 1'b0; en = 1'b0;
        check("R5 preset beats step up", int'(count), 0);
        setup(2'b01, 7, 1'b0);
        step_n(2);
        check("R3 down two steps", int'(count), 5);
        preset = 1'b1; en = 1'b1;
        cyc();
        preset = 1'b0; en = 1'b0;
        check("R5 preset beats step down", int'(count), 7);

        // Limit rewrite while running: grow
        setup(2'b00, 5, 1'b0);
        step_n(2);
        we = 1'b1; wdata = 16'd8; cyc();
        we = 1'b0;
        check("R9 pending while running", int'(max_busy), 1);
        we = 1'b1; wdata = 16'd1; cyc();
        we = 1'b0;
        step_n(3);
        check("R9 at old limit", int'(count), 5);
        check("R9 still pending", int'(max_busy), 1);
        step_n(1);
        check("R10 grow continues", int'(count), 6);
        check("R9 applied", int'(max_busy), 0);
        step_n(2);
        check("R10 reaches new limit", int'(count), 8);
        step_n(1);
        check("R10 wrap after new limit", int'(count), 0);
        check("R10 wrap event", int'(evt), 1);

        // Shrink below the count
        step_n(6);
        check("R10 count before shrink", int'(count), 6);
        we = 1'b1; wdata = 16'd3; cyc();
        we = 1'b0;
        we = 1'b1; wdata = 16'd6; cyc();
        we = 1'b0;
        step_n(2);
        check("R9 shrink pending at old limit", int'(count), 8);
        step_n(1);
        check("R10 shrink clears", int'(count), 0);
        check("R10 shrink event", int'(evt), 1);
        step_n(3);
        check("R9 dropped second write", int'(count), 3);
        step_n(1);
        check("R10 new period", int'(count), 0);
        check("R10 new period event", int'(evt), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule